// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined System Bus Manager

This block sits on the manager side of an AHB-style bus and turns one burst request into a stream of address phases. A request carries a start address, a beat width code and a 3-bit burst code. The sequencer then drives the per-beat address, the transfer type, the burst code and the size for every beat, and ends with an idle cycle. It supports single transfers, incrementing bursts of a caller-chosen length, and fixed bursts of 4, 8 or 16 beats in both a linear form and a wrapping form.

A request is taken only while the sequencer is idle and the bus is ready. After that, the address phase moves forward only on cycles where `hready` is high. A wrapping burst keeps every address inside an aligned block whose size is the beat count times the beat width. This lets a cache line fill start at the word that was missed and still cover the whole line. When the final beat has been accepted, the sequencer drives IDLE and pulses `done`.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `htrans` is IDLE (2'b00), `done` is low and `haddr` is zero.
- R2: The burst code decides the beat count: 3'b000 gives 1 beat, 3'b010 and 3'b011 give 4, 3'b100 and 3'b101 give 8, 3'b110 and 3'b111 give 16. Codes with bit 0 set are linear; the even codes other than 3'b000 wrap.
- R3: The first beat of a burst shows `htrans` NONSEQ (2'b10). Every later beat shows SEQ (2'b11).
- R4: In a linear burst (code 3'b001 or an odd fixed code), each beat's address is the previous beat's address plus 2^`hsize` bytes.
- R5: In a wrapping burst, the address also steps by 2^`hsize`, but it stays inside the block aligned to beats×2^`hsize`. From the block's last slot it folds back to the block base. For example, a 4-beat word burst from 0x4 gives 0x4, 0x8, 0xC, 0x0.
- R6: In a cycle where `hready` is low, `haddr`, `htrans`, `hburst` and `hsize` keep their values into the next cycle.
- R7: `hburst` and `hsize` are latched at the first beat and stay fixed for the whole burst. `start` and the request inputs are ignored while a burst is running.
- R8: The cycle after the final beat is accepted, `htrans` returns to IDLE and `done` is high for exactly one cycle.
- R9: For code 3'b001, `incr_len` gives the number of beats. A value of 0 is treated as one beat.
- R10: A request is accepted only when the sequencer is idle and `hready` is high. Its first beat appears on the outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request, sampled while idle and ready |
| start_addr | input | ADDR_W | Byte address of the first beat |
| size_in | input | 3 | Beat width code, bytes = 2^size_in |
| burst_in | input | 3 | Burst code (see R2) |
| incr_len | input | LEN_W | Beat count for the open-length linear code |
| hready | input | 1 | Bus ready; the address phase advances only when high |
| haddr | output | ADDR_W | Current beat address |
| htrans | output | 2 | Transfer type: IDLE 00, NONSEQ 10, SEQ 11 |
| hburst | output | 3 | Burst code of the running burst |
| hsize | output | 3 | Beat width code of the running burst |
| done | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
The bench keeps the default ADDR_W of 32 and LEN_W of 8. With these values, any start address can sit near the top of the address space, and open-length bursts of up to 255 beats can be requested; the bench draws lengths up to 20. Beat widths from one to four bytes are drawn with every burst code. Combined with 16-beat wrapping, this reaches blocks from 4 to 64 bytes and places the fold at every slot position. Random `hready` stalls and stray requests during a burst exercise the hold rule and the rule that a running burst ignores new requests.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_t;

  localparam logic [2:0] BC_SINGLE = 3'b000;
  localparam logic [2:0] BC_OPEN   = 3'b001;

  // wrapping codes: even and nonzero
  function automatic logic is_wrap_code(input logic [2:0] code);
    return (code[0] == 1'b0) && (code[2:1] != 2'b00);
  endfunction

  // log2 of the fixed beat count (4/8/16 -> 2/3/4)
  function automatic logic [3:0] fixed_len_log2(input logic [2:0] code);
    return {2'b00, code[2:1]} + 4'd1;
  endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic [2:0]       code,
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] last_idx
);

  logic [4:0] fixed_beats;

  always_comb begin
    fixed_beats = 5'd1 << fixed_len_log2(code);
    if (code == BC_SINGLE) begin
      last_idx = '0;
    end else if (code == BC_OPEN) begin
      if (len == '0) last_idx = '0;
      else           last_idx = CNT_W'(len - LEN_W'(1));
    end else begin
      last_idx = CNT_W'(fixed_beats - 5'd1);
    end
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [2:0]        code,
  output logic [ADDR_W-1:0] nxt
);

  logic              wrap;
  logic [3:0]        span_log2;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    wrap      = is_wrap_code(code);
    span_log2 = fixed_len_log2(code) + {1'b0, size};
    step      = ADDR_W'(1) << size;
    mask      = (ADDR_W'(1) << span_log2) - ADDR_W'(1);
    sum       = addr + step;
    if (wrap) nxt = (addr & ~mask) | (sum & mask);
    else      nxt = sum;
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        size_in,
  input  logic [2:0]        burst_in,
  input  logic [CNT_W-1:0]  last_idx,
  input  logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              done
);

  logic [ADDR_W-1:0] addr_q,   addr_d;
  trans_t            trans_q,  trans_d;
  logic [2:0]        burst_q,  burst_d;
  logic [2:0]        size_q,   size_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic              done_q,   done_d;
  logic              adv_en;
  logic              active;

  assign active = (trans_q != TR_IDLE);
  assign adv_en = hready;

  always_comb begin
    addr_d   = addr_q;
    trans_d  = trans_q;
    burst_d  = burst_q;
    size_d   = size_q;
    remain_d = remain_q;
    done_d   = 1'b0;
    if (hready) begin
      if (!active) begin
        if (start) begin
          addr_d   = start_addr;
          trans_d  = TR_NONSEQ;
          burst_d  = burst_in;
          size_d   = size_in;
          remain_d = last_idx;
        end
      end else if (remain_q == '0) begin
        trans_d = TR_IDLE;
        done_d  = 1'b1;
      end else begin
        addr_d   = next_addr;
        trans_d  = TR_SEQ;
        remain_d = remain_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      trans_q  <= TR_IDLE;
      burst_q  <= '0;
      size_q   <= '0;
      remain_q <= '0;
    end else if (adv_en) begin
      addr_q   <= addr_d;
      trans_q  <= trans_d;
      burst_q  <= burst_d;
      size_q   <= size_d;
      remain_q <= remain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign haddr  = addr_q;
  assign htrans = trans_q;
  assign hburst = burst_q;
  assign hsize  = size_q;
  assign done   = done_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        size_in,
  input  logic [2:0]        burst_in,
  input  logic [LEN_W-1:0]  incr_len,
  input  logic              hready,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              done
);

  localparam int CNT_W = (LEN_W > 4) ? LEN_W : 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [CNT_W-1:0]  last_idx;
  logic [ADDR_W-1:0] next_addr;

  burst_len_decode #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dec (
    .code     (burst_in),
    .len      (incr_len),
    .last_idx (last_idx)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .addr (haddr),
    .size (hsize),
    .code (hburst),
    .nxt  (next_addr)
  );

  burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .hready     (hready),
    .start      (start),
    .start_addr (start_addr),
    .size_in    (size_in),
    .burst_in   (burst_in),
    .last_idx   (last_idx),
    .next_addr  (next_addr),
    .haddr      (haddr),
    .htrans     (htrans),
    .hburst     (hburst),
    .hsize      (hsize),
    .done       (done)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hready,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic [2:0]        hburst,
  input logic [2:0]        hsize,
  input logic              done
);

  int unsigned blk_log2;
  assign blk_log2 = 32'(hburst[2:1]) + 32'd1 + 32'(hsize);

  // R3: a SEQ beat never follows an idle cycle
  a_r3_seq_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> ($past(htrans) != 2'b00));

  // R2: a single transfer never has a second beat
  a_r2_single_no_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> (hburst != 3'b000));

  // R6: stalled cycles keep the address phase
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(haddr) && $stable(htrans) && $stable(hburst) && $stable(hsize)));

  // R7: shape fixed during a burst
  a_r7_shape_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> ($stable(hburst) && $stable(hsize)));

  // R4: linear step
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11 && hburst[0] && $past(hready))
      |-> (haddr == $past(haddr) + (ADDR_W'(1) << hsize)));

  // R5: wrapping beats stay in one aligned block
  a_r5_wrap_block: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11 && !hburst[0]) |-> ((haddr >> blk_log2) == ($past(haddr) >> blk_log2)));

  // R8: done is a single pulse following an active beat
  a_r8_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (htrans == 2'b00 && $past(htrans) != 2'b00));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hready (hready),
  .haddr  (haddr),
  .htrans (htrans),
  .hburst (hburst),
  .hsize  (hsize),
  .done   (done)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic [2:0]        size_in;
  logic [2:0]        burst_in;
  logic [LEN_W-1:0]  incr_len;
  logic              hready;
  logic [ADDR_W-1:0] haddr;
  logic [1:0]        htrans;
  logic [2:0]        hburst;
  logic [2:0]        hsize;
  logic              done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .size_in(size_in), .burst_in(burst_in), .incr_len(incr_len),
    .hready(hready), .haddr(haddr), .htrans(htrans), .hburst(hburst),
    .hsize(hsize), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int beats_of(input logic [2:0] bt, input logic [LEN_W-1:0] ln);
    if (bt == 3'b000) return 1;
    if (bt == 3'b001) return (ln == 0) ? 1 : int'(ln);
    return 2 ** (int'(bt[2:1]) + 1);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_next(input logic [ADDR_W-1:0] a,
      input logic [2:0] sz, input logic [2:0] bt);
    logic [ADDR_W-1:0] w, blk, base;
    w = ADDR_W'(1) << sz;
    if (bt[0]) return a + w;
    blk  = ADDR_W'(beats_of(bt, '0)) * w;
    base = a - (a % blk);
    return base + ((a - base + w) % blk);
  endfunction

  task automatic run_burst(input logic [ADDR_W-1:0] a, input logic [2:0] sz,
      input logic [2:0] bt, input logic [LEN_W-1:0] ln, input int stall_pct, input bit poke);
    int total, k;
    bit rdy, stalled;
    logic [ADDR_W-1:0] ea;
    string rq;
    @(negedge clk);
    start = 1'b1; start_addr = a; size_in = sz; burst_in = bt; incr_len = ln; hready = 1'b1;
    @(negedge clk);
    start = 1'b0; start_addr = $urandom; burst_in = 3'($urandom); size_in = 3'($urandom);
    total = beats_of(bt, ln); k = 0; ea = a; stalled = 0;
    rq = (bt == 3'b001) ? "R9" : "R2";
    while (1) begin
      chk(htrans == ((k == 0) ? 2'b10 : 2'b11), stalled ? "R6" : (k == 0 ? "R10" : "R3"), 64'(htrans), (k == 0) ? 64'h2 : 64'h3);
      chk(haddr == ea, stalled ? "R6" : (bt[0] ? "R4" : "R5"), 64'(haddr), 64'(ea));
      chk(hburst == bt && hsize == sz, "R7", {58'd0, hburst, hsize}, {58'd0, bt, sz});
      chk(done == 1'b0, "R8", 64'(done), 64'h0);
      rdy = (($urandom % 100) >= stall_pct);
      hready = rdy;
      start = poke ? 1'($urandom) : 1'b0;
      start_addr = $urandom;
      incr_len = LEN_W'($urandom);
      @(negedge clk);
      stalled = !rdy;
      if (rdy) begin
        k++;
        if (k == total) break;
        ea = exp_next(ea, sz, bt);
      end
    end
    start = 1'b0; hready = 1'b1;
    chk(htrans == 2'b00, rq, 64'(htrans), 64'h0);
    chk(done == 1'b1, "R8", 64'(done), 64'h1);
    @(negedge clk);
    chk(done == 1'b0, "R8", 64'(done), 64'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240917));
    rst_n = 1'b0; start = 1'b0; start_addr = '0; size_in = '0; burst_in = '0;
    incr_len = '0; hready = 1'b1;
    repeat (3) @(negedge clk);
    chk(htrans == 2'b00 && done == 1'b0 && haddr == '0, "R1", {61'd0, htrans, done}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(htrans == 2'b00 && done == 1'b0 && haddr == '0, "R1", {61'd0, htrans, done}, 64'h0);

    // R10: request refused while hready is low
    start = 1'b1; start_addr = 32'h100; burst_in = 3'b011; size_in = 3'd2; hready = 1'b0;
    @(negedge clk);
    start = 1'b0; hready = 1'b1;
    chk(htrans == 2'b00, "R10", 64'(htrans), 64'h0);
    @(negedge clk);
    chk(htrans == 2'b00, "R10", 64'(htrans), 64'h0);

    // directed shapes
    run_burst(32'h4, 3'd2, 3'b010, 8'd0, 0, 0);   // R5: wrap4 word from 0x4
    run_burst(32'h4, 3'd2, 3'b011, 8'd0, 0, 0);   // R4: incr4 word from 0x4
    run_burst(32'h1C, 3'd2, 3'b100, 8'd0, 30, 1); // R5: wrap8 from last slot
    run_burst(32'h3D, 3'd0, 3'b110, 8'd0, 20, 1); // R5: wrap16 bytes
    run_burst(32'hFFFF_FFF8, 3'd1, 3'b111, 8'd0, 0, 0); // R4: incr16 past top
    run_burst(32'h80, 3'd2, 3'b000, 8'd7, 0, 1);  // R2: single
    run_burst(32'h200, 3'd2, 3'b001, 8'd0, 0, 0); // R9: length 0 -> 1 beat
    run_burst(32'h300, 3'd1, 3'b001, 8'd5, 40, 1);// R9: length 5

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0] sz, bt;
      logic [ADDR_W-1:0] a;
      sz = 3'($urandom % 3);
      bt = 3'($urandom);
      a  = $urandom & ~((ADDR_W'(1) << sz) - 1);
      run_burst(a, sz, bt, LEN_W'($urandom % 21), int'($urandom % 50), 1'($urandom));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule